// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full double-width product of two unsigned operands. It takes one clock cycle per multiplier bit, and it reuses one narrow adder on every one of those cycles. A caller raises `start` for one cycle while the block is idle, with both operands on the inputs. The block then runs one iteration per cycle and raises `done` for a single cycle when the product is ready on `product`.

The datapath has no separate register for the multiplier. The multiplier is loaded into the low half of the double-width product register, and the high half starts at zero. On each iteration the block looks at the register's least significant bit. When that bit is set, the fixed multiplicand is added into the high half. The whole register then moves right by one place, so the partial product fills in from the top while the multiplier bits drop out at the bottom. The carry from the narrow adder enters at the top bit during this shift. Callers that need signed results turn the operands into magnitudes before they present them.

Top module: `shift_add_mul`

## Requirements
- R1: During reset and in the first cycle after it, `busy` and `done` are low and `product` is zero.
- R2: A `start` pulse seen while `busy` is low is accepted on that clock edge, and `busy` is high in the following cycle.
- R3: An accepted operation runs exactly OP_W iterations. `busy` stays high and `done` stays low for OP_W cycles after the accepting edge. On the OP_W-th edge after it, `busy` falls and `done` rises.
- R4: `done` is high for exactly one cycle per operation.
- R5: When `done` is high, `product` equals the unsigned product of the multiplicand and the multiplier sampled on the accepting edge, over all 2*OP_W bits. This includes operands whose partial sums carry out of the narrow adder, for example all-ones times all-ones.
- R6: `start`, and any change of the operand inputs, while `busy` is high has no effect. The operation in flight finishes on time with the original product.
- R7: While `busy` is low and no `start` is applied, `product` holds its value.
- R8: In the cycle after an accepted `start`, `product` equals the multiplier zero-extended to 2*OP_W bits: the multiplier in the low half and zeros in the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| mcand_in | input | OP_W | Multiplicand, sampled when start is accepted |
| mplier_in | input | OP_W | Multiplier, sampled when start is accepted |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 2*OP_W | Product register contents |

## Verification
The assertions take for granted that `start` and the operand inputs are synchronous to `clk` and hold stable values at each rising edge. They place no limit on when `start` may appear, so a request during `busy` is legal input that the block must ignore. The bench changes all inputs only on falling edges. It deliberately raises `start` with different operands in the middle of an operation. It sweeps every operand pair of a 4-bit instance and checks a 32-bit instance with corner patterns and random values.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic step;
        logic last;
    } mul_ctl_t;

endpackage

// File: rtl/shift_add_mul_adder.sv
module shift_add_mul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);
    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
    end
endmodule

// File: rtl/shift_add_mul_ctrl.sv
module shift_add_mul_ctrl
    import shift_add_mul_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output mul_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OP_W - 1);

    mul_state_e       state_q;
    logic [CNT_W-1:0] iter_q;

    always_comb begin
        ctl.load = (state_q == MS_IDLE) && start;
        ctl.step = (state_q == MS_RUN);
        ctl.last = (state_q == MS_RUN) && (iter_q == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MS_IDLE;
            iter_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= ctl.last;
            unique case (state_q)
                MS_IDLE: begin
                    if (ctl.load) begin
                        state_q <= MS_RUN;
                        iter_q  <= '0;
                    end
                end
                MS_RUN: begin
                    iter_q <= iter_q + 1'b1;
                    if (ctl.last) begin
                        state_q <= MS_IDLE;
                    end
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end

    assign busy = (state_q == MS_RUN);
endmodule

// File: rtl/shift_add_mul_datapath.sv
module shift_add_mul_datapath
    import shift_add_mul_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  mul_ctl_t          ctl,
    input  logic [OP_W-1:0]   mcand_in,
    input  logic [OP_W-1:0]   mplier_in,
    output logic [2*OP_W-1:0] prod
);
    localparam int PW = 2 * OP_W;

    logic [OP_W-1:0] mcand_q;
    logic [PW-1:0]   prod_q;
    logic [OP_W:0]   add_sum;
    logic [OP_W:0]   upper_next;
    logic [PW-1:0]   shifted;

    shift_add_mul_adder #(.W(OP_W)) u_adder (
        .a   (prod_q[PW-1:OP_W]),
        .b   (mcand_q),
        .sum (add_sum)
    );

    // Upper half after the add decision, carry kept as its top bit,
    // then the whole register moves right one place.
    always_comb begin
        upper_next = prod_q[0] ? add_sum : {1'b0, prod_q[PW-1:OP_W]};
        shifted    = {upper_next, prod_q[OP_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (ctl.load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{OP_W{1'b0}}, mplier_in};
        end else if (ctl.step) begin
            prod_q  <= shifted;
        end
    end

    assign prod = prod_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import shift_add_mul_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand_in,
    input  logic [OP_W-1:0]   mplier_in,
    output logic              busy,
    output logic              done,
    output logic [2*OP_W-1:0] product
);
    mul_ctl_t ctl;

    shift_add_mul_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    shift_add_mul_datapath #(.OP_W(OP_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .prod      (product)
    );
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
    parameter int OP_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   mplier_in,
    input logic              busy,
    input logic              done,
    input logic [2*OP_W-1:0] product
);
    localparam int CW = $clog2(OP_W + 1) + 1;

    // Busy-cycle count since the last accepted start.
    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !done && product == '0));

    p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_window_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && run_cnt == CW'(OP_W)));

    p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    p_load_image_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (product == {{OP_W{1'b0}}, $past(mplier_in)}));
endmodule

bind shift_add_mul shift_add_mul_chk #(.OP_W(OP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mplier_in (mplier_in),
    .busy      (busy),
    .done      (done),
    .product   (product)
);

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
    logic        clk = 1'b0;
    logic        rst = 1'b1;

    logic        st32 = 1'b0;
    logic [31:0] a32 = '0;
    logic [31:0] b32 = '0;
    logic        busy32;
    logic        done32;
    logic [63:0] prod32;

    logic        st4 = 1'b0;
    logic [3:0]  a4 = '0;
    logic [3:0]  b4 = '0;
    logic        busy4;
    logic        done4;
    logic [7:0]  prod4;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    shift_add_mul #(.OP_W(32)) i_shift_add_mul (
        .clk(clk), .rst(rst), .start(st32), .mcand_in(a32), .mplier_in(b32),
        .busy(busy32), .done(done32), .product(prod32)
    );

    shift_add_mul #(.OP_W(4)) i_shift_add_mul_w4 (
        .clk(clk), .rst(rst), .start(st4), .mcand_in(a4), .mplier_in(b4),
        .busy(busy4), .done(done4), .product(prod4)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b, input bit poke);
        logic [63:0] exp;
        logic [63:0] held;
        exp = 64'(a) * 64'(b);
        @(negedge clk);
        a32 = a; b32 = b; st32 = 1'b1;
        @(negedge clk);
        st32 = 1'b0;
        check(busy32 && !done32, "R2", {62'b0, busy32, done32}, 64'h2);
        check(prod32 == {32'b0, b}, "R8", prod32, {32'b0, b});
        for (int i = 1; i < 32; i++) begin
            @(negedge clk);
            if (poke && i == 3) begin
                st32 = 1'b1; a32 = ~a; b32 = ~b;   // R6: request during busy
            end
            if (poke && i == 6) st32 = 1'b0;
            if (!(busy32 && !done32))
                check(1'b0, "R3", {62'b0, busy32, done32}, 64'h2);
        end
        @(negedge clk);
        check(done32 && !busy32, "R3", {62'b0, busy32, done32}, 64'h1);
        check(prod32 == exp, poke ? "R6" : "R5", prod32, exp);
        held = prod32;
        @(negedge clk);
        check(!done32, "R4", {63'b0, done32}, 64'h0);
        repeat (3) @(negedge clk);
        check(prod32 == held && !busy32, "R7", prod32, held);
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        a4 = a; b4 = b; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        repeat (4) @(negedge clk);
        check(done4 && prod4 == 8'(a) * 8'(b), "R5", {56'b0, prod4}, 64'(8'(a) * 8'(b)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle, zero product after reset
        check(!busy32 && !done32 && prod32 == '0, "R1", prod32, 64'h0);
        check(!busy4 && !done4 && prod4 == '0, "R1", {56'b0, prod4}, 64'h0);

        run32(32'd8, 32'd9, 1'b0);
        run32(32'd0, 32'd0, 1'b0);
        run32(32'd1, 32'd1, 1'b0);
        run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        run32(32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
        run32(32'hFFFF_FFFF, 32'd1, 1'b0);
        run32(32'd1, 32'hFFFF_FFFF, 1'b0);
        run32(32'd0, 32'hFFFF_FFFF, 1'b0);
        run32(32'h8000_0000, 32'h8000_0000, 1'b0);
        run32(32'd8, 32'd9, 1'b1);
        run32(32'hFFFF_FFFF, 32'h8000_0001, 1'b1);
        for (int k = 0; k < 24; k++) begin
            run32($urandom(), $urandom(), k[2]);
        end

        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                run4(4'(x), 4'(y));
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule